// File: doc/BRIEF.md
# Job Ring Index and Status Controller

This block keeps the bookkeeping for a pair of circular rings shared between software and a job engine: an input ring holding submitted jobs and an output ring holding completion entries. Software never moves pointers. It programs the size of each ring, then reports how many jobs it has placed in the input ring and how many completion entries it has taken out of the output ring. The block turns those counts into free-slot and occupied-slot figures and keeps the two hardware-owned head indices: where the engine reads the next job and where it writes the next completion.

The engine side is two strobes. `job_take_i` says a job was pulled from the input ring. `job_done_i` says a completion entry was written to the output ring. The block accepts a strobe only when the ring state allows it, and tracks the jobs that are in flight between the two. Count writes that would overflow a ring are refused and reported as typed errors. An interrupt is raised on completions, either per entry or coalesced by a count threshold and an idle timer. Processing can be set to halt on error. A ring reset command clears the bookkeeping, and it is refused while jobs are still in flight.

Register map (byte offsets on a 32-bit bus, reads are combinational on `addr_i`): 0x00 input size, 0x04 input slots free, 0x08 jobs added, 0x0C output size, 0x10 entries removed, 0x14 output slots full, 0x18 status, 0x1C configuration, 0x20 input read index, 0x24 output write index, 0x28 command. The write-only offsets read as zero.

Top module: `jr_ctrl`

## Requirements
- R1: After reset all registers read zero, and `irq_o`, `job_pending_o` and `out_room_o` are low.
- R2: The input size is held in bits 9:0 of offset 0x00. Offset 0x04 reads size minus pending jobs. Writing N (bits 9:0) to 0x08 with N not above the free count adds N pending jobs.
- R3: A write to 0x08 with N above the free count changes no count. It sets the error flag (status bit 1) with type 9 in status bits 11:8.
- R4: `job_take_i` is accepted only when at least one job is pending and processing is not halted. An accepted take frees one input slot, and it advances the read index at 0x20, which wraps to 0 at the input size. `job_pending_o` is high exactly when a take would be accepted.
- R5: `job_done_i` is accepted only when the output ring has a free slot (size in bits 9:0 of 0x0C) and a job is in flight. An accepted done raises the full count at 0x14 and advances the write index at 0x24, which wraps at the output size. `out_room_o` is high while full is below size.
- R6: Writing N to 0x10 frees N output entries. If N exceeds the full count the write is ignored and error type 8 is reported.
- R7: The error flag and its type are sticky. The first error wins until it is cleared by writing 1 to status bit 1. Status bit 0 (the interrupt flag) is cleared by writing 1 to it.
- R8: With configuration bit 2 set, a latched error halts processing and takes are refused. Status bits 3:2 then read 01 (0x4) while jobs are in flight and 10 (0x8) once none are.
- R9: Without coalescing, each accepted done sets status bit 0. `irq_o` is (bit 0 or bit 1) unless masked by configuration bit 0.
- R10: With coalescing on (configuration bit 1), status bit 0 is set when pending completions reach the count threshold in configuration bits 23:16 (0 acts as 1). The pending completions then restart from zero.
- R11: With coalescing on, a nonzero timer threshold in configuration bits 15:8 sets status bit 0 once completions have been pending for that many cycles. A zero threshold disables the timer.
- R12: Writing 1 to bit 0 of 0x28 with no job in flight clears the pending jobs, both indices, the full count, the interrupt flag and the coalescing state. With jobs in flight the command is ignored and error type 7 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| job_take_i | input | 1 | Engine pulled a job from the input ring |
| job_done_i | input | 1 | Engine wrote a completion entry |
| job_pending_o | output | 1 | A job may be taken |
| out_room_o | output | 1 | Output ring has a free slot |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong pending or full count shows up in the free or full register the same cycle it goes wrong. It also shows up in `job_pending_o` or `out_room_o` when the count reaches zero or the ring limit, so the bench compares every readable register and every output each cycle against a behavioural model. A broken index wrap shows in the index readback on the first pass around the ring. Errors in the coalescing counter or timer move the `irq_o` edge by at least one cycle. A wrongly latched or cleared error shows in the status word and in halted takes on the next strobe.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int THR_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN_SIZE  = 6'h00,
    REG_IN_AVAIL = 6'h04,
    REG_IN_ADD   = 6'h08,
    REG_OUT_SIZE = 6'h0C,
    REG_OUT_REM  = 6'h10,
    REG_OUT_FULL = 6'h14,
    REG_STATUS   = 6'h18,
    REG_CFG      = 6'h1C,
    REG_IN_IDX   = 6'h20,
    REG_OUT_IDX  = 6'h24,
    REG_CMD      = 6'h28
  } reg_addr_e;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_RESET   = 4'd7,
    ERR_REM_OVF = 4'd8,
    ERR_ADD_OVF = 4'd9
  } err_e;

  typedef enum logic [1:0] {
    HALT_NONE = 2'b00,
    HALT_BUSY = 2'b01,
    HALT_DONE = 2'b10
  } halt_e;
endpackage

// File: rtl/jr_in_ring.sv
module jr_in_ring #(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic             add_we_i,
  input  logic [IDX_W-1:0] add_n_i,
  input  logic             take_i,
  input  logic             block_i,
  output logic [IDX_W-1:0] avail_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             pend_nz_o,
  output logic             take_acc_o,
  output logic             add_ovf_o
);
  logic [IDX_W-1:0] pend_q, pend_d, idx_q, idx_d, add_amt;
  logic [IDX_W:0]   idx_inc;

  always_comb begin
    avail_o    = size_i - pend_q;
    pend_nz_o  = (pend_q != '0);
    add_ovf_o  = add_we_i && (add_n_i > avail_o);
    add_amt    = (add_we_i && !add_ovf_o) ? add_n_i : '0;
    take_acc_o = take_i && pend_nz_o && !block_i;
    pend_d     = pend_q + add_amt - {{(IDX_W-1){1'b0}}, take_acc_o};
    idx_inc    = {1'b0, idx_q} + 1'b1;
    idx_d      = idx_q;
    if (take_acc_o) idx_d = (idx_inc >= {1'b0, size_i}) ? '0 : idx_inc[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      idx_q  <= '0;
    end else if (clear_i) begin
      pend_q <= '0;
      idx_q  <= '0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
    end
  end

  assign rd_idx_o = idx_q;

  AST_ADD_OVF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_ovf_o && !clear_i |=> pend_q == $past(pend_q) - {{(IDX_W-1){1'b0}}, $past(take_acc_o)}); // R3

  AST_TAKE_NEEDS_JOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !pend_nz_o && !clear_i |=> rd_idx_o == $past(rd_idx_o)); // R4
endmodule

// File: rtl/jr_out_ring.sv
module jr_out_ring #(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic             rem_we_i,
  input  logic [IDX_W-1:0] rem_n_i,
  input  logic             done_i,
  input  logic             infl_nz_i,
  output logic [IDX_W-1:0] full_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             room_o,
  output logic             done_acc_o,
  output logic             rem_ovf_o
);
  logic [IDX_W-1:0] full_q, full_d, idx_q, idx_d, rem_amt;
  logic [IDX_W:0]   idx_inc;

  always_comb begin
    room_o     = (full_q < size_i);
    rem_ovf_o  = rem_we_i && (rem_n_i > full_q);
    rem_amt    = (rem_we_i && !rem_ovf_o) ? rem_n_i : '0;
    done_acc_o = done_i && room_o && infl_nz_i;
    full_d     = full_q - rem_amt + {{(IDX_W-1){1'b0}}, done_acc_o};
    idx_inc    = {1'b0, idx_q} + 1'b1;
    idx_d      = idx_q;
    if (done_acc_o) idx_d = (idx_inc >= {1'b0, size_i}) ? '0 : idx_inc[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      idx_q  <= '0;
    end else if (clear_i) begin
      full_q <= '0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      idx_q  <= idx_d;
    end
  end

  assign full_o   = full_q;
  assign wr_idx_o = idx_q;

  AST_DONE_FULL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !room_o && !rem_we_i && !clear_i |=> full_o == $past(full_o)); // R5

  AST_REM_OVF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_ovf_o && !clear_i |=> full_o == $past(full_o) + {{(IDX_W-1){1'b0}}, $past(done_acc_o)}); // R6
endmodule

// File: rtl/jr_coal.sv
module jr_coal #(
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [THR_W-1:0] cnt_thr_i,
  input  logic [THR_W-1:0] tmr_thr_i,
  input  logic             done_i,
  output logic             fire_o
);
  logic [THR_W:0]   cnt_q, cnt_inc, thr_eff, tmr_inc;
  logic [THR_W-1:0] tmr_q;
  logic             fire_cnt, fire_tmr;

  always_comb begin
    cnt_inc  = cnt_q + {{THR_W{1'b0}}, done_i};
    thr_eff  = (cnt_thr_i == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, cnt_thr_i};
    tmr_inc  = {1'b0, tmr_q} + 1'b1;
    fire_cnt = cnt_inc >= thr_eff;
    fire_tmr = (cnt_q != '0) && (tmr_thr_i != '0) && (tmr_inc >= {1'b0, tmr_thr_i});
    fire_o   = en_i ? (fire_cnt || fire_tmr) : done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (clear_i || !en_i || fire_o) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      cnt_q <= cnt_inc;
      tmr_q <= (cnt_q != '0) ? tmr_inc[THR_W-1:0] : '0;
    end
  end

  AST_COAL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && fire_o |=> cnt_q == '0); // R10

  AST_COAL_BELOW_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (cnt_thr_i != '0) && $stable(cnt_thr_i) |-> cnt_q < {1'b0, cnt_thr_i}); // R10
endmodule

// File: rtl/jr_ctrl.sv
module jr_ctrl
  import jr_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              job_take_i,
  input  logic              job_done_i,
  output logic              job_pending_o,
  output logic              out_room_o,
  output logic              irq_o
);
  localparam int INF_W = IDX_W + 2;

  logic [IDX_W-1:0] in_size_q, out_size_q;
  logic [IDX_W-1:0] in_avail, in_idx, out_full, out_idx;
  logic             cfg_mask_q, cfg_coal_q, cfg_stop_q;
  logic [THR_W-1:0] cfg_tmr_q, cfg_cnt_q;
  logic             irq_q, err_q;
  err_e             err_type_q, err_code;
  logic [INF_W-1:0] infl_q;
  logic             we_in_size, we_out_size, we_add, we_rem, we_status, we_cfg, we_cmd;
  logic             rst_ok, rst_bad, halted, block, pend_nz;
  logic             take_acc, done_acc, add_ovf, rem_ovf, fire;
  logic             clr_irq, clr_err;
  halt_e            halt_st;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:24];

  always_comb begin
    we_in_size  = wr_en_i && (addr_i == REG_IN_SIZE);
    we_out_size = wr_en_i && (addr_i == REG_OUT_SIZE);
    we_add      = wr_en_i && (addr_i == REG_IN_ADD);
    we_rem      = wr_en_i && (addr_i == REG_OUT_REM);
    we_status   = wr_en_i && (addr_i == REG_STATUS);
    we_cfg      = wr_en_i && (addr_i == REG_CFG);
    we_cmd      = wr_en_i && (addr_i == REG_CMD) && wdata_i[0];
    rst_ok      = we_cmd && (infl_q == '0);
    rst_bad     = we_cmd && (infl_q != '0);
    clr_irq     = we_status && wdata_i[0];
    clr_err     = we_status && wdata_i[1];
    halted      = err_q && cfg_stop_q;
    block       = halted || (infl_q == '1);
    job_pending_o = pend_nz && !block;
    if (add_ovf)      err_code = ERR_ADD_OVF;
    else if (rem_ovf) err_code = ERR_REM_OVF;
    else if (rst_bad) err_code = ERR_RESET;
    else              err_code = ERR_NONE;
    if (!halted)              halt_st = HALT_NONE;
    else if (infl_q != '0)    halt_st = HALT_BUSY;
    else                      halt_st = HALT_DONE;
  end

  jr_in_ring #(.IDX_W(IDX_W)) u_in (
    .clk_i, .rst_ni, .clear_i(rst_ok), .size_i(in_size_q),
    .add_we_i(we_add), .add_n_i(wdata_i[IDX_W-1:0]),
    .take_i(job_take_i), .block_i(block),
    .avail_o(in_avail), .rd_idx_o(in_idx), .pend_nz_o(pend_nz),
    .take_acc_o(take_acc), .add_ovf_o(add_ovf)
  );

  jr_out_ring #(.IDX_W(IDX_W)) u_out (
    .clk_i, .rst_ni, .clear_i(rst_ok), .size_i(out_size_q),
    .rem_we_i(we_rem), .rem_n_i(wdata_i[IDX_W-1:0]),
    .done_i(job_done_i), .infl_nz_i(infl_q != '0),
    .full_o(out_full), .wr_idx_o(out_idx), .room_o(out_room_o),
    .done_acc_o(done_acc), .rem_ovf_o(rem_ovf)
  );

  jr_coal #(.THR_W(THR_W)) u_coal (
    .clk_i, .rst_ni, .clear_i(rst_ok), .en_i(cfg_coal_q),
    .cnt_thr_i(cfg_cnt_q), .tmr_thr_i(cfg_tmr_q),
    .done_i(done_acc), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_size_q  <= '0;
      out_size_q <= '0;
      cfg_mask_q <= 1'b0;
      cfg_coal_q <= 1'b0;
      cfg_stop_q <= 1'b0;
      cfg_tmr_q  <= '0;
      cfg_cnt_q  <= '0;
    end else begin
      if (we_in_size)  in_size_q  <= wdata_i[IDX_W-1:0];
      if (we_out_size) out_size_q <= wdata_i[IDX_W-1:0];
      if (we_cfg) begin
        cfg_mask_q <= wdata_i[0];
        cfg_coal_q <= wdata_i[1];
        cfg_stop_q <= wdata_i[2];
        cfg_tmr_q  <= wdata_i[15:8];
        cfg_cnt_q  <= wdata_i[23:16];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      infl_q     <= '0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      err_type_q <= ERR_NONE;
    end else begin
      if (rst_ok) infl_q <= '0;
      else        infl_q <= infl_q + {{(INF_W-1){1'b0}}, take_acc} - {{(INF_W-1){1'b0}}, done_acc};
      if (rst_ok)       irq_q <= 1'b0;
      else if (fire)    irq_q <= 1'b1;
      else if (clr_irq) irq_q <= 1'b0;
      if (!err_q && err_code != ERR_NONE) begin
        err_q      <= 1'b1;
        err_type_q <= err_code;
      end else if (clr_err) begin
        err_q      <= 1'b0;
        err_type_q <= ERR_NONE;
      end
    end
  end

  assign irq_o = (irq_q || err_q) && !cfg_mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_IN_SIZE:  rdata_o[IDX_W-1:0] = in_size_q;
      REG_IN_AVAIL: rdata_o[IDX_W-1:0] = in_avail;
      REG_OUT_SIZE: rdata_o[IDX_W-1:0] = out_size_q;
      REG_OUT_FULL: rdata_o[IDX_W-1:0] = out_full;
      REG_STATUS:   rdata_o[11:0] = {err_type_q, 4'b0, halt_st, err_q, irq_q};
      REG_CFG:      rdata_o[23:0] = {cfg_cnt_q, cfg_tmr_q, 5'b0, cfg_stop_q, cfg_coal_q, cfg_mask_q};
      REG_IN_IDX:   rdata_o[IDX_W-1:0] = in_idx;
      REG_OUT_IDX:  rdata_o[IDX_W-1:0] = out_idx;
      default:      rdata_o = '0;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_err |=> err_q && $stable(err_type_q)); // R7

  AST_HALT_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |-> !take_acc); // R8

  AST_RST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ok |=> out_full == '0 && in_idx == '0 && out_idx == '0 && !irq_q); // R12

  AST_RST_CMD_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_bad && !err_q |=> err_q && err_type_q == ERR_RESET); // R12

  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mask_q && !we_cfg |=> !irq_o); // R9
endmodule

// File: tb/jr_ctrl_bench.sv
module jr_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        job_take_i = 1'b0;
  logic        job_done_i = 1'b0;
  logic        job_pending_o, out_room_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  jr_ctrl u_jr_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .job_take_i, .job_done_i, .job_pending_o, .out_room_o, .irq_o
  );

  // behavioural model
  int m_isz, m_osz, m_pend, m_ridx, m_full, m_widx, m_infl;
  int m_irq, m_err, m_etype, m_mask, m_coal, m_stop, m_tthr, m_cthr, m_cnt, m_tmr;

  function automatic int m_read(input int a);
    int h, hs;
    h  = m_err && m_stop;
    hs = !h ? 0 : (m_infl != 0 ? 1 : 2);
    case (a)
      'h00: return m_isz;
      'h04: return m_isz - m_pend;
      'h0C: return m_osz;
      'h14: return m_full;
      'h18: return (m_etype << 8) | (hs << 2) | (m_err << 1) | m_irq;
      'h1C: return m_mask | (m_coal << 1) | (m_stop << 2) | (m_tthr << 8) | (m_cthr << 16);
      'h20: return m_ridx;
      'h24: return m_widx;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_isz = 0; m_osz = 0; m_pend = 0; m_ridx = 0; m_full = 0; m_widx = 0; m_infl = 0;
      m_irq = 0; m_err = 0; m_etype = 0; m_mask = 0; m_coal = 0; m_stop = 0;
      m_tthr = 0; m_cthr = 0; m_cnt = 0; m_tmr = 0;
    end else begin
      int h, tk, dn, addn, remn, code, rstok, clri, clre, fire, cinc, thr, n, a, d;
      a = int'(addr_i); d = int'(wdata_i);
      h = m_err && m_stop;
      tk = job_take_i && m_pend > 0 && !h && m_infl < 4095;
      dn = job_done_i && m_full < m_osz && m_infl > 0;
      addn = 0; remn = 0; code = 0; rstok = 0; clri = 0; clre = 0;
      n = d & 1023;
      if (wr_en_i) begin
        case (a)
          'h08: if (n > m_isz - m_pend) code = 9; else addn = n;
          'h10: if (n > m_full) code = 8; else remn = n;
          'h18: begin clri = d & 1; clre = (d >> 1) & 1; end
          'h28: if (d & 1) begin if (m_infl != 0) code = 7; else rstok = 1; end
          default: ;
        endcase
      end
      cinc = m_cnt + dn;
      if (m_coal) begin
        thr = (m_cthr == 0) ? 1 : m_cthr;
        fire = (cinc >= thr) || (m_cnt != 0 && m_tthr != 0 && m_tmr + 1 >= m_tthr);
      end else fire = dn;
      if (rstok || !m_coal || fire) begin m_cnt = 0; m_tmr = 0; end
      else begin m_tmr = (m_cnt != 0) ? ((m_tmr + 1) & 255) : 0; m_cnt = cinc; end
      if (rstok) m_irq = 0; else if (fire) m_irq = 1; else if (clri) m_irq = 0;
      if (!m_err && code != 0) begin m_err = 1; m_etype = code; end
      else if (clre) begin m_err = 0; m_etype = 0; end
      if (rstok) begin
        m_pend = 0; m_ridx = 0; m_full = 0; m_widx = 0; m_infl = 0;
      end else begin
        m_pend = m_pend + addn - tk;
        if (tk) m_ridx = (m_ridx + 1 >= m_isz) ? 0 : m_ridx + 1;
        m_full = m_full - remn + dn;
        if (dn) m_widx = (m_widx + 1 >= m_osz) ? 0 : m_widx + 1;
        m_infl = m_infl + tk - dn;
      end
      if (wr_en_i && a == 'h00) m_isz = n;
      if (wr_en_i && a == 'h0C) m_osz = n;
      if (wr_en_i && a == 'h1C) begin
        m_mask = d & 1; m_coal = (d >> 1) & 1; m_stop = (d >> 2) & 1;
        m_tthr = (d >> 8) & 255; m_cthr = (d >> 16) & 255;
      end
    end
    #5;
    if (rst_ni && !finished) begin
      check({cur_tag, " rdata"}, int'(rdata_o), m_read(int'(addr_i)));
      check({cur_tag, " irq_o"}, int'(irq_o), int'((m_irq || m_err) && !m_mask));
      check({cur_tag, " job_pending_o"}, int'(job_pending_o),
            int'(m_pend > 0 && !(m_err && m_stop) && m_infl < 4095));
      check({cur_tag, " out_room_o"}, int'(out_room_o), int'(m_full < m_osz));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 6'(a); wdata_i = 32'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    @(negedge clk_i);
    addr_i = 6'(a);
    #1 check(tag, int'(rdata_o), exp);
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); job_take_i = 1'b1;
    end
    @(negedge clk_i); job_take_i = 1'b0;
  endtask

  task automatic done(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); job_done_i = 1'b1;
    end
    @(negedge clk_i); job_done_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    cur_tag = "R1";
    for (int a = 0; a <= 'h28; a += 4) rd_exp(a, 0, "R1 reset register");
    #1 check("R1 irq_o", int'(irq_o), 0);
    check("R1 out_room_o", int'(out_room_o), 0);
    check("R1 job_pending_o", int'(job_pending_o), 0);

    cur_tag = "R2";
    wr('h00, 8); wr('h0C, 4);
    wr('h08, 5);
    rd_exp('h04, 3, "R2 free after add");
    cur_tag = "R3";
    wr('h08, 4);
    rd_exp('h18, 'h902, "R3 add overflow status");
    rd_exp('h04, 3, "R3 free unchanged");
    cur_tag = "R7";
    wr('h10, 1000);
    rd_exp('h18, 'h902, "R7 first error kept");
    wr('h18, 2);
    rd_exp('h18, 0, "R7 error cleared");
    cur_tag = "R2";
    wr('h08, 3);
    rd_exp('h04, 0, "R2 ring filled");

    cur_tag = "R4";
    take(6);
    rd_exp('h20, 6, "R4 read index");
    rd_exp('h04, 6, "R4 slots freed");
    cur_tag = "R5";
    done(5);
    rd_exp('h14, 4, "R5 full capped at size");
    rd_exp('h24, 0, "R5 write index wrapped");
    #1 check("R5 out_room_o", int'(out_room_o), 0);
    cur_tag = "R6";
    wr('h10, 5);
    rd_exp('h18, 'h803, "R6 remove overflow status");
    wr('h18, 3);
    wr('h10, 2);
    rd_exp('h14, 2, "R6 entries freed");
    cur_tag = "R4";
    take(3);
    rd_exp('h20, 0, "R4 read index wrapped");
    done(2); wr('h10, 4); done(2); wr('h10, 2);

    cur_tag = "R8";
    wr('h18, 1);
    wr('h1C, 4);
    wr('h08, 2);
    take(1);
    wr('h08, 100);
    rd_exp('h18, 'h906, "R8 halt in progress");
    take(1);
    rd_exp('h20, 1, "R8 take refused while halted");
    done(1);
    rd_exp('h18, 'h90B, "R8 halt complete");
    wr('h18, 2);
    take(1);
    rd_exp('h20, 2, "R8 take after clear");

    cur_tag = "R9";
    wr('h1C, 1);
    done(1);
    #1 check("R9 masked irq_o", int'(irq_o), 0);
    rd_exp('h18, 1, "R9 flag set under mask");
    wr('h1C, 0);
    #1 check("R9 unmasked irq_o", int'(irq_o), 1);

    cur_tag = "R12";
    wr('h18, 1);
    wr('h08, 1); take(1);
    wr('h28, 1);
    rd_exp('h18, 'h702, "R12 reset refused in flight");
    wr('h18, 2);
    done(1);
    wr('h28, 1);
    rd_exp('h18, 0, "R12 status after reset");
    rd_exp('h14, 0, "R12 full cleared");
    rd_exp('h20, 0, "R12 read index cleared");
    rd_exp('h04, 8, "R12 free restored");

    cur_tag = "R10";
    wr('h1C, 'h00030002);
    wr('h08, 6); take(6);
    done(2);
    #1 check("R10 below threshold", int'(irq_o), 0);
    done(1);
    #1 check("R10 threshold reached", int'(irq_o), 1);
    wr('h18, 1);
    wr('h10, 3);

    cur_tag = "R11";
    wr('h1C, 'h000A0502);
    done(1);
    idle(2);
    #1 check("R11 timer not yet expired", int'(irq_o), 0);
    idle(8);
    #1 check("R11 timer expired", int'(irq_o), 1);
    wr('h18, 1);
    wr('h1C, 'h00020002);
    done(1);
    idle(20);
    #1 check("R11 zero timer disabled", int'(irq_o), 0);

    idle(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule